// File: doc/BRIEF.md
# Per-Processor Interrupt Acknowledge Unit

This unit sits between the interrupt routing logic and a single processor. It keeps a small table of per-source settings (priority, vector, edge or level sense) and a per-source activity flag. It also keeps two membership sets. The first holds the sources that have been raised toward the processor. The second holds the sources the processor has taken and not yet finished. A 4-bit task priority register blocks low-priority work. The unit drives one interrupt line toward the processor.

The routing logic presents a source index as an offer. The unit looks up that source's priority, accepts or drops the offer, and decides whether the line must go high. The processor then issues an acknowledge request. One cycle later it gets a strobe with either the vector of the best raised source or a spurious vector, when the set is empty or the chosen entry has gone stale. An end-of-interrupt request retires the most urgent in-service source and raises the line again if raised work now outranks what remains. The activity flags go out to the routing logic. The routing logic clears a flag through a dedicated input when a level source drops.

Top module: `pic_ack_unit`

## Requirements
- R1: After synchronous reset:
  - irq_out and ack_valid are low.
  - All activity flags and both sets are empty.
  - The task priority is all ones (0xF), so no offer is accepted.
  - The spurious vector is 0xFF.
  - Every table entry holds priority 0, vector 0 and edge sense.
- R2: An offer whose table priority is not strictly greater than the task priority is dropped: the raised set and irq_out stay as they were. A task priority write (tp_we) takes effect from the next cycle.
- R3: An offer for a source already in the raised set is dropped, and its activity flag is not set again.
- R4: An accepted offer sets the source's activity flag and raised bit in the next cycle. irq_out goes high in the next cycle only if the offered priority is greater than or equal to both of these: the highest raised priority and the highest in-service priority. An empty set does not block. Otherwise irq_out keeps its value.
- R5: Every highest-priority search uses strictly-greater comparison, so among equal priorities the lowest source index is chosen.
- R6: On ack_req, the cycle after shows irq_out low and ack_valid high for exactly that one cycle, with ack_vec valid. An empty raised set returns the spurious vector, which is written through spv_we.
- R7: If the chosen raised source is inactive, or its priority is no longer above the task priority, it happens as follows. Its activity flag is cleared, it leaves the raised set, and ack_vec carries the spurious vector.
- R8: Otherwise the chosen source leaves the raised set, enters the in-service set, and its vector is returned. An edge source (sense bit 0) has its activity flag cleared. A level source (sense bit 1) keeps its flag.
- R9: eoi_req removes the highest-priority in-service source, or nothing if that set is empty. irq_out then goes high if the raised set is non-empty and either of these holds: the remaining in-service set is empty, or the best raised priority is strictly above the best remaining in-service priority. Otherwise irq_out keeps its value.
- R10: A table write replaces priority, vector and sense of one source, and leaves its activity flag and set membership unchanged.
- R11: At most one set-changing operation acts per cycle, with precedence ack_req over eoi_req over offer_valid. The lower ones in that cycle are ignored.
- R12: clr_act_valid clears the named source's activity flag and wins over an offer that sets the same flag in the same cycle. Offer and clear indices at or above N_SRC are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one source table entry |
| cfg_idx | input | IDX_W | Source index for the table write |
| cfg_prio | input | 4 | New source priority |
| cfg_vec | input | 8 | New source vector |
| cfg_level | input | 1 | New sense: 1 level, 0 edge |
| tp_we | input | 1 | Write task priority |
| tp_val | input | 4 | New task priority |
| spv_we | input | 1 | Write spurious vector |
| spv_val | input | 8 | New spurious vector |
| offer_valid | input | 1 | Routing logic offers a source |
| offer_src | input | IDX_W | Offered source index |
| clr_act_valid | input | 1 | Clear one activity flag |
| clr_act_src | input | IDX_W | Source whose activity flag is cleared |
| ack_req | input | 1 | Processor acknowledge read |
| eoi_req | input | 1 | Processor end-of-interrupt write |
| irq_out | output | 1 | Interrupt line to the processor |
| ack_valid | output | 1 | Acknowledge data strobe |
| ack_vec | output | 8 | Acknowledge vector or spurious vector |
| src_active | output | N_SRC | Per-source activity flags |

## Verification
The bench builds the unit with N_SRC = 20. This count is not a power of two, so the 5-bit source index can name values 20 to 31 that must be ignored. The top source, index 19, sits in the last slice of the search loop. The 4-bit task priority keeps its full range, which reaches the reset value 15 where even the highest source priority is refused. Tie-breaking, stale acknowledges, in-service masking, end-of-interrupt re-arming and same-cycle conflicts are all reachable with a handful of configured sources.

// File: rtl/pic_ack_pkg.sv
package pic_ack_pkg;

    localparam int PRIO_W = 4;
    localparam int VEC_W  = 8;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [VEC_W-1:0]  vec_t;

    typedef struct packed {
        prio_t prio;
        vec_t  vec;
        logic  level;
    } src_cfg_t;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_OFFER,
        OP_EOI,
        OP_ACK
    } op_e;

    typedef enum logic [1:0] {
        ACK_EMPTY,
        ACK_STALE,
        ACK_GRANT
    } ack_kind_e;

    // acknowledge beats end-of-interrupt, which beats an offer
    function automatic op_e sel_op(input logic ack, input logic eoi, input logic offer);
        if (ack)
            return OP_ACK;
        else if (eoi)
            return OP_EOI;
        else if (offer)
            return OP_OFFER;
        return OP_IDLE;
    endfunction

endpackage

// File: rtl/pic_src_table.sv
module pic_src_table
    import pic_ack_pkg::*;
#(
    parameter int N_SRC = 16,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  src_cfg_t              wr_cfg,
    input  logic [N_SRC-1:0]      act_set,
    input  logic [N_SRC-1:0]      act_clr,
    output prio_t [N_SRC-1:0]     prio_o,
    output vec_t  [N_SRC-1:0]     vec_o,
    output logic  [N_SRC-1:0]     level_o,
    output logic  [N_SRC-1:0]     act_o
);

    src_cfg_t cfg_q [N_SRC];
    logic     act_q [N_SRC];

    for (genvar g = 0; g < N_SRC; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[g] <= '0;
                act_q[g] <= 1'b0;
            end else begin
                if (wr_en && (wr_idx == IDX_W'(g)))
                    cfg_q[g] <= wr_cfg;
                if (act_clr[g])
                    act_q[g] <= 1'b0;
                else if (act_set[g])
                    act_q[g] <= 1'b1;
            end
        end

        assign prio_o[g]  = cfg_q[g].prio;
        assign vec_o[g]   = cfg_q[g].vec;
        assign level_o[g] = cfg_q[g].level;
        assign act_o[g]   = act_q[g];
    end

endmodule

// File: rtl/pic_prio_pick.sv
module pic_prio_pick
    import pic_ack_pkg::*;
#(
    parameter int N_SRC = 16,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic  [N_SRC-1:0] members,
    input  prio_t [N_SRC-1:0] prio_tab,
    output logic              found,
    output logic [IDX_W-1:0]  idx,
    output prio_t             prio
);

    // strictly-greater scan: the lowest index keeps a tie
    always_comb begin
        found = 1'b0;
        idx   = '0;
        prio  = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (members[i] && (!found || (prio_tab[i] > prio))) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                prio  = prio_tab[i];
            end
        end
    end

endmodule

// File: rtl/pic_ack_unit.sv
module pic_ack_unit
    import pic_ack_pkg::*;
#(
    parameter int N_SRC = 16,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [3:0]        cfg_prio,
    input  logic [7:0]        cfg_vec,
    input  logic              cfg_level,
    input  logic              tp_we,
    input  logic [3:0]        tp_val,
    input  logic              spv_we,
    input  logic [7:0]        spv_val,
    input  logic              offer_valid,
    input  logic [IDX_W-1:0]  offer_src,
    input  logic              clr_act_valid,
    input  logic [IDX_W-1:0]  clr_act_src,
    input  logic              ack_req,
    input  logic              eoi_req,
    output logic              irq_out,
    output logic              ack_valid,
    output logic [7:0]        ack_vec,
    output logic [N_SRC-1:0]  src_active
);

    localparam logic [N_SRC-1:0] ONE = N_SRC'(1);

    // ---------------- state ----------------
    logic [N_SRC-1:0] raised_q, inserv_q;
    prio_t            tp_q;
    vec_t             spv_q;

    // ---------------- source table ----------------
    prio_t [N_SRC-1:0] prio_tab;
    vec_t  [N_SRC-1:0] vec_tab;
    logic  [N_SRC-1:0] level_tab;
    logic  [N_SRC-1:0] act_set, act_clr;
    src_cfg_t          cfg_new;

    assign cfg_new = '{prio: cfg_prio, vec: cfg_vec, level: cfg_level};

    pic_src_table #(.N_SRC(N_SRC)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_cfg  (cfg_new),
        .act_set (act_set),
        .act_clr (act_clr),
        .prio_o  (prio_tab),
        .vec_o   (vec_tab),
        .level_o (level_tab),
        .act_o   (src_active)
    );

    // ---------------- priority searches ----------------
    logic             r_found, s_found, s2_found;
    logic [IDX_W-1:0] r_idx, s_idx, s2_idx;
    prio_t            r_prio, s_prio, s2_prio;
    logic [N_SRC-1:0] r_mask, s_mask, inserv_left;

    pic_prio_pick #(.N_SRC(N_SRC)) u_pick_raised (
        .members (raised_q), .prio_tab (prio_tab),
        .found (r_found), .idx (r_idx), .prio (r_prio)
    );

    pic_prio_pick #(.N_SRC(N_SRC)) u_pick_inserv (
        .members (inserv_q), .prio_tab (prio_tab),
        .found (s_found), .idx (s_idx), .prio (s_prio)
    );

    assign r_mask      = r_found ? (ONE << r_idx) : '0;
    assign s_mask      = s_found ? (ONE << s_idx) : '0;
    assign inserv_left = inserv_q & ~s_mask;

    // what stays in service once the top entry retires
    pic_prio_pick #(.N_SRC(N_SRC)) u_pick_left (
        .members (inserv_left), .prio_tab (prio_tab),
        .found (s2_found), .idx (s2_idx), .prio (s2_prio)
    );

    // ---------------- operation decode ----------------
    logic             off_in_range, clr_in_range;
    logic [IDX_W-1:0] off_idx;
    prio_t            off_prio;
    op_e              op;
    logic             accept, outranks, eoi_rearm;
    ack_kind_e        ack_kind;
    logic             clear_on_ack;

    assign off_in_range = 32'(offer_src) < N_SRC;
    assign clr_in_range = 32'(clr_act_src) < N_SRC;
    assign off_idx      = off_in_range ? offer_src : '0;
    assign off_prio     = prio_tab[off_idx];
    assign op           = sel_op(ack_req, eoi_req, offer_valid && off_in_range);

    assign accept   = (op == OP_OFFER) && (off_prio > tp_q) && !raised_q[off_idx];
    assign outranks = (!r_found || (off_prio >= r_prio)) &&
                      (!s_found || (off_prio >= s_prio));

    assign eoi_rearm = r_found && (!s2_found || (r_prio > s2_prio));

    always_comb begin
        if (!r_found)
            ack_kind = ACK_EMPTY;
        else if (!src_active[r_idx] || (prio_tab[r_idx] <= tp_q))
            ack_kind = ACK_STALE;
        else
            ack_kind = ACK_GRANT;
    end

    assign clear_on_ack = (op == OP_ACK) &&
                          ((ack_kind == ACK_STALE) ||
                           ((ack_kind == ACK_GRANT) && !level_tab[r_idx]));

    assign act_set = accept ? (ONE << off_idx) : '0;
    assign act_clr = ((clr_act_valid && clr_in_range) ? (ONE << clr_act_src) : '0) |
                     (clear_on_ack ? r_mask : '0);

    // ---------------- registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            raised_q  <= '0;
            inserv_q  <= '0;
            tp_q      <= '1;
            spv_q     <= '1;
            irq_out   <= 1'b0;
            ack_valid <= 1'b0;
            ack_vec   <= '0;
        end else begin
            if (tp_we)
                tp_q <= tp_val;
            if (spv_we)
                spv_q <= spv_val;

            ack_valid <= (op == OP_ACK);

            unique case (op)
                OP_ACK: begin
                    irq_out  <= 1'b0;
                    raised_q <= raised_q & ~r_mask;
                    if (ack_kind == ACK_GRANT) begin
                        inserv_q <= inserv_q | r_mask;
                        ack_vec  <= vec_tab[r_idx];
                    end else begin
                        ack_vec  <= spv_q;
                    end
                end
                OP_EOI: begin
                    inserv_q <= inserv_left;
                    if (eoi_rearm)
                        irq_out <= 1'b1;
                end
                OP_OFFER: begin
                    if (accept) begin
                        raised_q <= raised_q | act_set;
                        if (outranks)
                            irq_out <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pic_ack_unit_chk.sv
module pic_ack_unit_chk
    import pic_ack_pkg::*;
#(
    parameter int N_SRC = 16,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             ack_req,
    input logic             eoi_req,
    input logic             offer_valid,
    input logic [IDX_W-1:0] offer_src,
    input logic             clr_act_valid,
    input logic [IDX_W-1:0] clr_act_src,
    input logic             irq_out,
    input logic             ack_valid,
    input logic [7:0]       ack_vec,
    input logic [N_SRC-1:0] src_active,
    input logic [N_SRC-1:0] raised_q,
    input logic [N_SRC-1:0] inserv_q,
    input prio_t            tp_q,
    input vec_t             spv_q,
    input prio_t            off_prio
);

    logic offer_alone;
    assign offer_alone = offer_valid && !ack_req && !eoi_req && (32'(offer_src) < N_SRC);

    p_ack_drops_irq_r6: assert property (@(posedge clk) disable iff (rst)
        ack_req |=> !irq_out);

    p_ack_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        ack_req |=> ack_valid);

    p_no_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        !ack_req |=> !ack_valid);

    p_empty_spurious_r6: assert property (@(posedge clk) disable iff (rst)
        (ack_req && (raised_q == '0)) |=> (ack_vec == $past(spv_q)));

    p_low_offer_drop_r2: assert property (@(posedge clk) disable iff (rst)
        (offer_alone && (off_prio <= tp_q)) |=> $stable(raised_q));

    p_accept_marks_r4: assert property (@(posedge clk) disable iff (rst)
        (offer_alone && (off_prio > tp_q) && !raised_q[offer_src] &&
         !(clr_act_valid && (clr_act_src == offer_src)))
        |=> (src_active[$past(offer_src)] && raised_q[$past(offer_src)]));

    p_eoi_pops_r9: assert property (@(posedge clk) disable iff (rst)
        (eoi_req && !ack_req) |=>
        (($past(inserv_q) == '0) ? (inserv_q == '0)
                                 : ($countones(inserv_q) == $countones($past(inserv_q)) - 1)));

endmodule

bind pic_ack_unit pic_ack_unit_chk #(.N_SRC(N_SRC)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ack_req       (ack_req),
    .eoi_req       (eoi_req),
    .offer_valid   (offer_valid),
    .offer_src     (offer_src),
    .clr_act_valid (clr_act_valid),
    .clr_act_src   (clr_act_src),
    .irq_out       (irq_out),
    .ack_valid     (ack_valid),
    .ack_vec       (ack_vec),
    .src_active    (src_active),
    .raised_q      (raised_q),
    .inserv_q      (inserv_q),
    .tp_q          (tp_q),
    .spv_q         (spv_q),
    .off_prio      (off_prio)
);

// File: tb/pic_ack_unit_bench.sv
`timescale 1ns/1ps
module pic_ack_unit_bench;

    localparam int NS = 20;
    localparam int IW = $clog2(NS);

    localparam logic [2:0] K_CFG = 3'd1, K_TP = 3'd2, K_SPV = 3'd3,
                           K_OFF = 3'd4, K_ACK = 3'd5, K_EOI = 3'd6;

    typedef struct packed {
        logic [2:0]    op;
        logic [IW-1:0] idx;
        logic [3:0]    prio;
        logic [7:0]    vec;
        logic          lvl;
        logic          xirq;
        logic          chk;
        logic [7:0]    xvec;
        logic [3:0]    req;
    } step_t;

    // op, idx, prio, vec, level, expected irq, check ack, expected vector, requirement
    localparam step_t STEPS [26] = '{
        '{K_CFG, 5'd1,  4'd3,  8'h11, 1'b0, 1'b0, 1'b0, 8'h00, 4'd10}, // R10
        '{K_CFG, 5'd2,  4'd6,  8'h22, 1'b0, 1'b0, 1'b0, 8'h00, 4'd10},
        '{K_CFG, 5'd5,  4'd6,  8'h55, 1'b0, 1'b0, 1'b0, 8'h00, 4'd10},
        '{K_CFG, 5'd7,  4'd9,  8'h77, 1'b1, 1'b0, 1'b0, 8'h00, 4'd10},
        '{K_CFG, 5'd19, 4'd12, 8'h99, 1'b0, 1'b0, 1'b0, 8'h00, 4'd10},
        '{K_TP,  5'd0,  4'd2,  8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 4'd2},  // R2
        '{K_OFF, 5'd1,  4'd0,  8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 4'd4},  // R4
        '{K_ACK, 5'd0,  4'd0,  8'h00, 1'b0, 1'b0, 1'b1, 8'h11, 4'd8},  // R8
        '{K_OFF, 5'd2,  4'd0,  8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 4'd4},
        '{K_OFF, 5'd5,  4'd0,  8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 4'd4},
        '{K_ACK, 5'd0,  4'd0,  8'h00, 1'b0, 1'b0, 1'b1, 8'h22, 4'd5},  // R5 tie
        '{K_EOI, 5'd0,  4'd0,  8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 4'd9},  // R9 rearm
        '{K_ACK, 5'd0,  4'd0,  8'h00, 1'b0, 1'b0, 1'b1, 8'h55, 4'd8},
        '{K_EOI, 5'd0,  4'd0,  8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 4'd9},
        '{K_EOI, 5'd0,  4'd0,  8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 4'd9},
        '{K_EOI, 5'd0,  4'd0,  8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 4'd9},
        '{K_ACK, 5'd0,  4'd0,  8'h00, 1'b0, 1'b0, 1'b1, 8'hFF, 4'd6},  // R6 empty
        '{K_SPV, 5'd0,  4'd0,  8'h3C, 1'b0, 1'b0, 1'b0, 8'h00, 4'd6},
        '{K_ACK, 5'd0,  4'd0,  8'h00, 1'b0, 1'b0, 1'b1, 8'h3C, 4'd6},
        '{K_TP,  5'd0,  4'd5,  8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 4'd2},
        '{K_OFF, 5'd1,  4'd0,  8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 4'd2},
        '{K_ACK, 5'd0,  4'd0,  8'h00, 1'b0, 1'b0, 1'b1, 8'h3C, 4'd2},
        '{K_OFF, 5'd19, 4'd0,  8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 4'd4},
        '{K_TP,  5'd0,  4'd12, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 4'd7},  // R7
        '{K_ACK, 5'd0,  4'd0,  8'h00, 1'b0, 1'b0, 1'b1, 8'h3C, 4'd7},
        '{K_ACK, 5'd0,  4'd0,  8'h00, 1'b0, 1'b0, 1'b1, 8'h3C, 4'd7}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_we, cfg_level, tp_we, spv_we, offer_valid, clr_act_valid, ack_req, eoi_req;
    logic [IW-1:0] cfg_idx, offer_src, clr_act_src;
    logic [3:0]    cfg_prio, tp_val;
    logic [7:0]    cfg_vec, spv_val;
    logic          irq_out, ack_valid;
    logic [7:0]    ack_vec;
    logic [NS-1:0] src_active;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pic_ack_unit #(.N_SRC(NS)) u_pic_ack_unit (
        .clk (clk), .rst (rst),
        .cfg_we (cfg_we), .cfg_idx (cfg_idx), .cfg_prio (cfg_prio),
        .cfg_vec (cfg_vec), .cfg_level (cfg_level),
        .tp_we (tp_we), .tp_val (tp_val), .spv_we (spv_we), .spv_val (spv_val),
        .offer_valid (offer_valid), .offer_src (offer_src),
        .clr_act_valid (clr_act_valid), .clr_act_src (clr_act_src),
        .ack_req (ack_req), .eoi_req (eoi_req),
        .irq_out (irq_out), .ack_valid (ack_valid), .ack_vec (ack_vec),
        .src_active (src_active)
    );

    task automatic idle_in();
        cfg_we = 0; cfg_idx = '0; cfg_prio = '0; cfg_vec = '0; cfg_level = 0;
        tp_we = 0; tp_val = '0; spv_we = 0; spv_val = '0;
        offer_valid = 0; offer_src = '0; clr_act_valid = 0; clr_act_src = '0;
        ack_req = 0; eoi_req = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle_in();
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_ack(input string tag, input logic [7:0] exp);
        check({tag, " strobe"}, int'(ack_valid), 1);
        check({tag, " vector"}, int'(ack_vec), int'(exp));
    endtask

    task automatic do_cfg(input int i, input int p, input int v, input bit l);
        cfg_we = 1; cfg_idx = IW'(i); cfg_prio = 4'(p); cfg_vec = 8'(v); cfg_level = l; tick();
    endtask
    task automatic do_tp(input int p);    tp_we = 1; tp_val = 4'(p); tick(); endtask
    task automatic do_offer(input int i); offer_valid = 1; offer_src = IW'(i); tick(); endtask
    task automatic do_clr(input int i);   clr_act_valid = 1; clr_act_src = IW'(i); tick(); endtask
    task automatic do_ack();              ack_req = 1; tick(); endtask
    task automatic do_eoi();              eoi_req = 1; tick(); endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic apply_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 irq at reset", int'(irq_out), 0);
        check("R1 strobe at reset", int'(ack_valid), 0);
        check("R1 activity at reset", int'(src_active), 0);
        rst = 1'b0;
    endtask

    initial begin
        idle_in();
        apply_reset();

        // table walk
        foreach (STEPS[k]) begin
            case (STEPS[k].op)
                K_CFG: do_cfg(int'(STEPS[k].idx), int'(STEPS[k].prio), int'(STEPS[k].vec), STEPS[k].lvl);
                K_TP:  do_tp(int'(STEPS[k].prio));
                K_SPV: begin spv_we = 1; spv_val = STEPS[k].vec; tick(); end
                K_OFF: do_offer(int'(STEPS[k].idx));
                K_ACK: do_ack();
                K_EOI: do_eoi();
                default: tick();
            endcase
            check($sformatf("R%0d step %0d irq", STEPS[k].req, k), int'(irq_out), int'(STEPS[k].xirq));
            if (STEPS[k].chk)
                chk_ack($sformatf("R%0d step %0d", STEPS[k].req, k), STEPS[k].xvec);
            else
                check($sformatf("R%0d step %0d no strobe", STEPS[k].req, k), int'(ack_valid), 0);
        end

        // R1: task priority and spurious vector return to their reset values
        apply_reset();
        do_cfg(3, 15, 8'h33, 1'b0);
        do_offer(3);
        check("R1 top priority refused by reset task priority", int'(irq_out), 0);
        do_ack();
        chk_ack("R1 reset spurious", 8'hFF);
        do_tp(2);

        // R8: level keeps activity, edge loses it
        do_cfg(7, 9, 8'h77, 1'b1);
        do_offer(7);
        check("R4 level offer irq", int'(irq_out), 1);
        check("R4 level offer active", int'(src_active[7]), 1);
        do_ack();
        chk_ack("R8 level grant", 8'h77);
        check("R8 level stays active", int'(src_active[7]), 1);
        do_eoi();
        do_cfg(4, 8, 8'h44, 1'b0);
        do_offer(4);
        check("R4 edge offer active", int'(src_active[4]), 1);
        do_ack();
        chk_ack("R8 edge grant", 8'h44);
        check("R8 edge activity cleared", int'(src_active[4]), 0);
        do_eoi();

        // R3: a duplicate offer does not revive activity
        do_offer(7);
        do_clr(7);
        check("R12 clear input", int'(src_active[7]), 0);
        do_offer(7);
        check("R3 duplicate offer leaves activity clear", int'(src_active[7]), 0);
        do_ack();
        chk_ack("R7 inactive source gives spurious", 8'hFF);
        check("R7 irq low", int'(irq_out), 0);

        // R10: table rewrite keeps activity
        do_offer(7);
        do_cfg(7, 10, 8'h70, 1'b1);
        check("R10 activity kept over table write", int'(src_active[7]), 1);
        do_ack();
        chk_ack("R10 new vector used", 8'h70);
        do_eoi();

        // R11: precedence
        ack_req = 1; offer_valid = 1; offer_src = IW'(4); tick();
        chk_ack("R11 ack wins over offer", 8'hFF);
        check("R11 offer ignored activity", int'(src_active[4]), 0);
        eoi_req = 1; offer_valid = 1; offer_src = IW'(4); tick();
        check("R11 eoi wins over offer irq", int'(irq_out), 0);
        check("R11 eoi wins over offer activity", int'(src_active[4]), 0);
        do_ack();
        chk_ack("R11 raised set still empty", 8'hFF);

        // R12: clear beats set in the same cycle
        offer_valid = 1; offer_src = IW'(4); clr_act_valid = 1; clr_act_src = IW'(4); tick();
        check("R12 clear wins activity", int'(src_active[4]), 0);
        check("R12 offer still raised irq", int'(irq_out), 1);
        do_ack();
        chk_ack("R7 stale after clear", 8'hFF);

        // R4 hidden by in-service, R9 rearm on retire
        do_offer(7);
        do_ack();
        chk_ack("R8 grant before masking", 8'h70);
        do_offer(4);
        check("R4 lower offer hidden by in-service", int'(irq_out), 0);
        check("R4 hidden offer still active", int'(src_active[4]), 1);
        do_eoi();
        check("R9 rearm with empty in-service", int'(irq_out), 1);
        do_ack();
        chk_ack("R9 pending source delivered", 8'h44);
        do_eoi();

        // R12: out-of-range index ignored
        do_offer(25);
        check("R12 out-of-range offer irq", int'(irq_out), 0);
        do_ack();
        chk_ack("R12 out-of-range offer not raised", 8'hFF);

        report();
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        report();
    end

endmodule